// File: doc/BRIEF.md
# Segmented Byte-Store Access Controller

This block sits behind a byte-level serial slave and in front of a 512-byte nonvolatile store. The slave reports transaction events: a start carrying a segment select and a read/write flag, each received byte, requests for read bytes, and the stop. The controller keeps a byte pointer, decides what each byte offset refers to, and returns or accepts data to match. The two 256-byte segments are picked by the segment bit of the start. Most offsets are array cells. A few are reserved and read as FFh. Six offsets in the lower segment are volatile control registers that take writes at once.

Write data aimed at array cells is gathered in a 16-byte page buffer. At the stop the whole page is committed in one program cycle. The program cycle is a parameterized busy countdown, and any new start is refused while it runs, so a host can poll for the end of the cycle with starts. A write-protect input, sampled at the stop, discards the gathered page. Reads are never affected by write-protect. Lower-segment offsets 75h to 77h hold a mode byte and the power-up PIO defaults. They are ordinary array cells here.

Top module: `seg_mem_ctrl`

## Requirements
- R1: `txn_seg`=0 selects the lower segment and 1 the upper one. The same offset in the two segments is separate storage.
- R2: `start_ack` is 1 in a cycle with `txn_start` when no program cycle runs, and 0 while `busy` is 1. A refused start changes nothing.
- R3: A stop ending a write that placed at least one byte into array cells raises `busy` on the next clock edge. `busy` then stays high for exactly PROG_CYCLES cycles. A write that placed no array bytes leaves `busy` low.
- R4: When `wp` is 1 at the stop, nothing is programmed and `busy` stays low. Reads are unaffected by `wp`.
- R5: Lower offsets 78h–79h and upper offsets F0h–FFh read as FFh, and writes to them are ignored.
- R6: Lower offsets 7Ah–7Fh are volatile registers. A data byte written there appears on `vreg_q` after the edge that takes it: offset 7Ah+k maps to bits [8k+7:8k]. It reads back, never starts a program cycle, and resets to 00h.
- R7: In a write, the first byte after the start sets the pointer. Each data byte then advances only the low 4 pointer bits, so bytes past the end of the aligned 16-byte page land from the page start, and a later byte to the same cell wins.
- R8: Each read byte advances the pointer by one, wrapping from FFh to 00h in the same segment.
- R9: A read started without a preceding address continues from the pointer left by the last transaction.
- R10: A repeated start after write data abandons the gathered page: nothing is programmed.
- R11: After reset, `busy`, `rd_vld` and `vreg_q` are all 0.
- R12: `rd_vld` is a one-cycle pulse in the cycle after a `rd_req` in a read transaction, with the byte on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp | input | 1 | Write-protect for all array cells |
| txn_start | input | 1 | Start or repeated start with device byte received |
| txn_seg | input | 1 | Segment select for the starting transaction |
| txn_read | input | 1 | 1 for a read transaction |
| start_ack | output | 1 | Acknowledge for the device byte |
| wr_vld | input | 1 | A write byte is present |
| wr_byte | input | 8 | Write byte (first one is the offset) |
| rd_req | input | 1 | Request the next read byte |
| rd_vld | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| txn_stop | input | 1 | Stop condition |
| busy | output | 1 | Program cycle running |
| vreg_q | output | 48 | Volatile register contents |

## Verification
The bench goes after page boundaries: a pointer that carried into the next page would scatter bytes across two pages, and a seventeenth byte would not replace the first. It writes across the reserved and volatile window of the lower segment. A decoder that missed the window would program reserved cells, fail to return FFh, or start a useless busy period. It reads across offset FFh, where a pointer leaking into the segment bit would read the other segment. It also probes starts during the program cycle, a protected write, and a repeated start that must drop a gathered page. Each of these shows a wrong design as a wrong acknowledge, a wrong busy length, or stale or altered data on readback.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int SEG_AW    = 8;
  localparam int VOL_BYTES = 6;
  localparam logic [7:0] LO_RSV_FIRST = 8'h78;
  localparam logic [7:0] LO_RSV_LAST  = 8'h79;
  localparam logic [7:0] VOL_FIRST    = 8'h7A;
  localparam logic [7:0] VOL_LAST     = 8'h7F;
  localparam logic [7:0] HI_RSV_FIRST = 8'hF0;
  localparam logic [7:0] FILL_BYTE    = 8'hFF;

  typedef enum logic [1:0] {RG_ARRAY, RG_VOL, RG_RSVD} region_t;
  typedef enum logic [1:0] {ST_IDLE, ST_WADDR, ST_WDATA, ST_READ} mac_state_t;

  function automatic region_t region_of(input logic seg, input logic [7:0] off);
    region_t r;
    r = RG_ARRAY;
    if (!seg) begin
      if (off >= LO_RSV_FIRST && off <= LO_RSV_LAST) r = RG_RSVD;
      else if (off >= VOL_FIRST && off <= VOL_LAST)  r = RG_VOL;
    end else if (off >= HI_RSV_FIRST) begin
      r = RG_RSVD;
    end
    return r;
  endfunction
endpackage

// File: rtl/mac_page_buf.sv
module mac_page_buf #(
  parameter int PAGE_BYTES = 16,
  localparam int PG_W = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    we,
  input  logic [PG_W-1:0]         idx,
  input  logic [7:0]              din,
  output logic [PAGE_BYTES*8-1:0] data,
  output logic [PAGE_BYTES-1:0]   mask
);
  logic [PAGE_BYTES-1:0] mask_d;

  always_comb begin
    mask_d = mask;
    if (clr) mask_d = '0;
    else if (we) mask_d[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_d;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    logic lane_en;
    assign lane_en = we && !clr && (idx == PG_W'(g));
    always_ff @(posedge clk) begin
      if (lane_en) data[g*8 +: 8] <= din;
    end
  end
endmodule

// File: rtl/mac_vregs.sv
module mac_vregs #(
  parameter int NREG = 6,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        din,
  output logic [NREG*8-1:0] q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic en;
    assign en = we && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[g*8 +: 8] <= 8'h00;
      else if (en) q[g*8 +: 8] <= din;
    end
  end
endmodule

// File: rtl/mac_nvm.sv
module mac_nvm #(
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 500000,
  localparam int PG_W   = $clog2(PAGE_BYTES),
  localparam int AW     = 9,
  localparam int NBYTES = 1 << AW,
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prog_go,
  input  logic [AW-PG_W-1:0]      prog_page,
  input  logic [PAGE_BYTES*8-1:0] prog_data,
  input  logic [PAGE_BYTES-1:0]   prog_mask,
  input  logic [AW-1:0]           rd_addr,
  output logic [7:0]              rd_data,
  output logic                    busy
);
  logic [7:0]       mem [NBYTES];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_d;

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (prog_go && prog_mask[i]) mem[{prog_page, PG_W'(i)}] <= prog_data[i*8 +: 8];
    end
  end

  assign rd_data = mem[rd_addr];

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    if (prog_go) begin
      cnt_d  = CNT_W'(PROG_CYCLES - 1);
      busy_d = 1'b1;
    end else if (busy) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
    end
  end
endmodule

// File: rtl/seg_mem_ctrl.sv
module seg_mem_ctrl
  import mac_pkg::*;
#(
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 500000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wp,
  input  logic                   txn_start,
  input  logic                   txn_seg,
  input  logic                   txn_read,
  output logic                   start_ack,
  input  logic                   wr_vld,
  input  logic [7:0]             wr_byte,
  input  logic                   rd_req,
  output logic                   rd_vld,
  output logic [7:0]             rd_data,
  input  logic                   txn_stop,
  output logic                   busy,
  output logic [VOL_BYTES*8-1:0] vreg_q
);
  localparam int PG_W   = $clog2(PAGE_BYTES);
  localparam int VIDX_W = $clog2(VOL_BYTES);

  mac_state_t            st_q, st_d;
  logic [SEG_AW-1:0]     addr_q, addr_d;
  logic                  seg_q, seg_d;
  logic                  buf_clr, buf_we, vol_we, prog_go, rd_fire;
  logic [PAGE_BYTES*8-1:0] pg_data;
  logic [PAGE_BYTES-1:0] pg_mask;
  logic [7:0]            arr_byte, rd_mux;
  logic [VIDX_W-1:0]     vidx;
  region_t               cur_rg;

  assign cur_rg    = region_of(seg_q, addr_q);
  assign vidx      = VIDX_W'(addr_q - VOL_FIRST);
  assign start_ack = txn_start && !busy;

  // sequencing of transaction events
  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    seg_d   = seg_q;
    buf_clr = 1'b0;
    buf_we  = 1'b0;
    vol_we  = 1'b0;
    prog_go = 1'b0;
    rd_fire = 1'b0;
    if (start_ack) begin
      seg_d   = txn_seg;
      st_d    = txn_read ? ST_READ : ST_WADDR;
      buf_clr = 1'b1;
    end else if (txn_stop) begin
      st_d    = ST_IDLE;
      buf_clr = 1'b1;
      prog_go = (st_q == ST_WDATA) && (|pg_mask) && !wp;
    end else if (wr_vld && st_q == ST_WADDR) begin
      addr_d = wr_byte;
      st_d   = ST_WDATA;
    end else if (wr_vld && st_q == ST_WDATA) begin
      buf_we = (cur_rg == RG_ARRAY);
      vol_we = (cur_rg == RG_VOL);
      addr_d = {addr_q[SEG_AW-1:PG_W], PG_W'(addr_q[PG_W-1:0] + 1'b1)};
    end else if (rd_req && st_q == ST_READ) begin
      rd_fire = 1'b1;
      addr_d  = addr_q + 1'b1;
    end
  end

  always_comb begin
    case (cur_rg)
      RG_ARRAY: rd_mux = arr_byte;
      RG_VOL:   rd_mux = vreg_q[vidx*8 +: 8];
      default:  rd_mux = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      seg_q  <= 1'b0;
      rd_vld <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      seg_q  <= seg_d;
      rd_vld <= rd_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= 8'h00;
    else if (rd_fire) rd_data <= rd_mux;
  end

  mac_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
    .clk (clk), .rst_n (rst_n), .clr (buf_clr), .we (buf_we),
    .idx (addr_q[PG_W-1:0]), .din (wr_byte), .data (pg_data), .mask (pg_mask)
  );

  mac_vregs #(.NREG(VOL_BYTES)) u_vreg (
    .clk (clk), .rst_n (rst_n), .we (vol_we), .idx (vidx), .din (wr_byte), .q (vreg_q)
  );

  mac_nvm #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_nvm (
    .clk (clk), .rst_n (rst_n), .prog_go (prog_go),
    .prog_page ({seg_q, addr_q[SEG_AW-1:PG_W]}), .prog_data (pg_data),
    .prog_mask (pg_mask), .rd_addr ({seg_q, addr_q}), .rd_data (arr_byte), .busy (busy)
  );
endmodule

// File: rtl/seg_mem_ctrl_chk.sv
module seg_mem_ctrl_chk
  import mac_pkg::*;
#(
  parameter int PROG_CYCLES = 500000
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wp,
  input logic                   txn_start,
  input logic                   start_ack,
  input logic                   wr_vld,
  input logic                   rd_req,
  input logic                   rd_vld,
  input logic [7:0]             rd_data,
  input logic                   busy,
  input logic [VOL_BYTES*8-1:0] vreg_q,
  input logic                   seg_q,
  input logic [7:0]             addr_q
);
  logic [31:0] blen_q;
  logic        rsvd_now;

  assign rsvd_now = (region_of(seg_q, addr_q) == RG_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blen_q <= '0;
    else if (busy) blen_q <= blen_q + 1'b1;
    else           blen_q <= '0;
  end

  // R2
  nack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_ack);

  // R2
  ack_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_start && !busy) |-> start_ack);

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen_q == PROG_CYCLES));

  // R4
  wp_noprog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp && !busy) |=> !busy);

  // R5
  rsvd_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rsvd_now && !start_ack) |=> (!rd_vld || rd_data == 8'hFF));

  // R6
  vreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vld |=> $stable(vreg_q));

  // R12
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $past(rd_req));
endmodule

bind seg_mem_ctrl seg_mem_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk (clk), .rst_n (rst_n), .wp (wp), .txn_start (txn_start),
  .start_ack (start_ack), .wr_vld (wr_vld), .rd_req (rd_req), .rd_vld (rd_vld),
  .rd_data (rd_data), .busy (busy), .vreg_q (vreg_q), .seg_q (seg_q), .addr_q (addr_q)
);

// File: tb/sim_seg_mem_ctrl.sv
module sim_seg_mem_ctrl;
  localparam int PROG = 40;
  localparam logic [2:0] SW = 3'd0, SR = 3'd1, BY = 3'd2, RD = 3'd3, SP = 3'd4, WT = 3'd5;
  localparam int NV = 64;
  // entry: {op, segment, byte (sent or expected), requirement number}
  localparam logic [19:0] TBL [NV] = '{
    {SW,1'b0,8'h00,8'd3}, {BY,1'b0,8'h10,8'd3}, {BY,1'b0,8'hA1,8'd3}, {BY,1'b0,8'hA2,8'd3},
    {BY,1'b0,8'hA3,8'd3}, {SP,1'b0,8'h00,8'd3}, {WT,1'b0,8'h00,8'd3},
    // R1 same offset in the upper segment
    {SW,1'b1,8'h00,8'd1}, {BY,1'b1,8'h10,8'd1}, {BY,1'b1,8'hB1,8'd1}, {SP,1'b0,8'h00,8'd1},
    {WT,1'b0,8'h00,8'd1},
    {SW,1'b0,8'h00,8'd1}, {BY,1'b0,8'h10,8'd1}, {SR,1'b0,8'h00,8'd1},
    {RD,1'b0,8'hA1,8'd1}, {RD,1'b0,8'hA2,8'd8}, {RD,1'b0,8'hA3,8'd8},
    {SW,1'b1,8'h00,8'd1}, {BY,1'b1,8'h10,8'd1}, {SR,1'b1,8'h00,8'd1}, {RD,1'b1,8'hB1,8'd1},
    // R5 / R6 reserved and volatile window
    {SW,1'b0,8'h00,8'd5}, {BY,1'b0,8'h78,8'd5}, {BY,1'b0,8'h12,8'd5}, {BY,1'b0,8'h34,8'd5},
    {BY,1'b0,8'h56,8'd6}, {SP,1'b0,8'h00,8'd5},
    {SW,1'b0,8'h00,8'd5}, {BY,1'b0,8'h78,8'd5}, {SR,1'b0,8'h00,8'd5},
    {RD,1'b0,8'hFF,8'd5}, {RD,1'b0,8'hFF,8'd5}, {RD,1'b0,8'h56,8'd6},
    {SW,1'b1,8'h00,8'd5}, {BY,1'b1,8'hF0,8'd5}, {SR,1'b1,8'h00,8'd5}, {RD,1'b1,8'hFF,8'd5},
    // R8 end of segment
    {SW,1'b0,8'h00,8'd8}, {BY,1'b0,8'hFE,8'd8}, {BY,1'b0,8'hC1,8'd8}, {BY,1'b0,8'hC2,8'd8},
    {SP,1'b0,8'h00,8'd8}, {WT,1'b0,8'h00,8'd8},
    // R7 page wrap
    {SW,1'b0,8'h00,8'd7}, {BY,1'b0,8'h0E,8'd7}, {BY,1'b0,8'hE0,8'd7}, {BY,1'b0,8'hE1,8'd7},
    {BY,1'b0,8'hE2,8'd7}, {SP,1'b0,8'h00,8'd7}, {WT,1'b0,8'h00,8'd7},
    {SW,1'b0,8'h00,8'd8}, {BY,1'b0,8'hFE,8'd8}, {SR,1'b0,8'h00,8'd8},
    {RD,1'b0,8'hC1,8'd8}, {RD,1'b0,8'hC2,8'd8}, {RD,1'b0,8'hE2,8'd8},
    // R9 current address read
    {SW,1'b0,8'h00,8'd9}, {BY,1'b0,8'h0E,8'd9}, {SR,1'b0,8'h00,8'd9}, {RD,1'b0,8'hE0,8'd7},
    {SP,1'b0,8'h00,8'd9}, {SR,1'b0,8'h00,8'd9}, {RD,1'b0,8'hE1,8'd9}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp = 1'b0, txn_start = 1'b0, txn_seg = 1'b0, txn_read = 1'b0;
  logic wr_vld = 1'b0, rd_req = 1'b0, txn_stop = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic start_ack, rd_vld, busy;
  logic [7:0] rd_data;
  logic [47:0] vreg_q;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  seg_mem_ctrl #(.PAGE_BYTES(16), .PROG_CYCLES(PROG)) u0 (
    .clk, .rst_n, .wp, .txn_start, .txn_seg, .txn_read, .start_ack, .wr_vld, .wr_byte,
    .rd_req, .rd_vld, .rd_data, .txn_stop, .busy, .vreg_q
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_start(input logic s, input logic rd, output logic ack);
    txn_start = 1'b1; txn_seg = s; txn_read = rd;
    #1 ack = start_ack;
    step();
    txn_start = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    wr_vld = 1'b1; wr_byte = b;
    step();
    wr_vld = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] d, output logic v);
    rd_req = 1'b1;
    step();
    rd_req = 1'b0;
    v = rd_vld; d = rd_data;
  endtask

  task automatic do_stop();
    txn_stop = 1'b1;
    step();
    txn_stop = 1'b0;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 10000 && busy; g++) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R3: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack, v;
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 busy at reset", busy, 0);
    check("R11 rd_vld at reset", rd_vld, 0);
    check("R11 vreg_q at reset", int'(vreg_q == 48'h0), 1);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      op = TBL[i][19:17];
      case (op)
        SW, SR: begin
          do_start(TBL[i][16], op == SR, ack);
          check($sformatf("R2 table[%0d] start ack", i), ack, 1);
        end
        BY: send(TBL[i][15:8]);
        RD: begin
          do_read(d, v);
          check($sformatf("R12 table[%0d] rd_vld", i), v, 1);
          check($sformatf("R%0d table[%0d] data", TBL[i][7:0], i), d, TBL[i][15:8]);
        end
        SP: do_stop();
        default: wait_idle();
      endcase
    end
    do_stop();
    // R12 pulse is one cycle wide
    check("R12 rd_vld drops", rd_vld, 0);
    // R6 byte at 7Ah on vreg_q[7:0]
    check("R6 vreg_q[7:0]", vreg_q[7:0], 8'h56);

    // R6 / R3 volatile-only write starts no program cycle
    do_start(1'b0, 1'b0, ack); send(8'h7F); send(8'h9A); do_stop();
    check("R3 no busy after volatile write", busy, 0);
    check("R6 vreg_q[47:40]", vreg_q[47:40], 8'h9A);

    // R3 busy length, R2 nack during busy
    do_start(1'b0, 1'b0, ack); send(8'h30); send(8'h77); do_stop();
    check("R3 busy after page write", busy, 1);
    do_start(1'b0, 1'b1, ack);
    check("R2 nack while busy", ack, 0);
    n = 0;
    for (int g = 0; g < 1000 && busy; g++) begin n++; step(); end
    check("R3 busy remaining cycles", n, PROG - 1);
    do_start(1'b0, 1'b0, ack);
    check("R2 ack after busy", ack, 1);
    send(8'h30); do_start(1'b0, 1'b1, ack); do_read(d, v);
    check("R3 programmed byte", d, 8'h77);
    do_stop();

    // R4 write-protect
    wp = 1'b1;
    do_start(1'b0, 1'b0, ack); send(8'h30); send(8'h55); do_stop();
    check("R4 no busy under wp", busy, 0);
    do_start(1'b0, 1'b0, ack); send(8'h30); do_start(1'b0, 1'b1, ack); do_read(d, v);
    check("R4 read under wp", d, 8'h77);
    do_stop();
    wp = 1'b0;

    // R10 repeated start drops the gathered page
    do_start(1'b0, 1'b0, ack); send(8'h30); send(8'h44);
    do_start(1'b0, 1'b0, ack); do_stop();
    check("R10 no busy after abandoned page", busy, 0);
    do_start(1'b0, 1'b0, ack); send(8'h30); do_start(1'b0, 1'b1, ack); do_read(d, v);
    check("R10 cell unchanged", d, 8'h77);
    do_stop();

    // R7 seventeen bytes into page 20h
    do_start(1'b0, 1'b0, ack); send(8'h20);
    for (int k = 0; k < 16; k++) send(8'(k));
    send(8'h99); do_stop(); wait_idle();
    do_start(1'b0, 1'b0, ack); send(8'h20); do_start(1'b0, 1'b1, ack);
    do_read(d, v); check("R7 17th byte overwrote page start", d, 8'h99);
    do_read(d, v); check("R7 second cell kept", d, 8'h01);
    do_stop();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule